// File: doc/BRIEF.md
# Descriptor-ring receive DMA channel

This block moves received frames into memory. Frames arrive as 32-bit words on a valid/ready stream, and the last word of each frame is flagged. Software places buffer descriptors in a ring in memory, sets the ring base, and moves a posted pointer forward as it hands buffers to the channel. The channel reads each descriptor through a descriptor read port. It then writes the frame words through a request/grant write master. When the frame is complete, it writes a one-word status header in front of the data.

Each descriptor gives a buffer address and a byte count. A frame that does not fit in its first buffer continues in the buffers that follow. The header records the frame length, an overflow flag and how many descriptors the frame took. If the posted buffers run out in the middle of a frame, one control bit selects what happens. With the bit set, the channel drops the rest of the frame and continues. With the bit clear, the channel halts with an error code. A status word reports the ring position, the channel state and the error cause.

Top module: `rxdma_chan`

## Requirements
- R1: After reset the status word is 0 (state disabled), `in_ready` is low and no request is raised. Clearing the enable bit from any state returns the channel to disabled. It also returns the ring position to 0 and clears the error code.
- R2: When the ring position equals the posted pointer at the start of a frame, the state reads idle wait (2) and `in_ready` stays low.
- R3: The first buffer of a frame holds the header at buffer address plus frame offset. Frame words follow in consecutive word addresses from buffer address plus offset plus 4. Each write request keeps its address and data until it is granted.
- R4: The header word is written after the last frame word is accepted. It holds the frame length in bytes (4 per word) in bits [15:0], the overflow flag in bit 23, and the descriptor count minus one in bits [27:24].
- R5: When a buffer has less than one word left, the frame continues from the start of the next posted descriptor's buffer, with no offset. At most one memory request (descriptor or write) is raised at a time. No word is accepted while a write is pending.
- R6: A descriptor is read at ring base plus ring position. The ring position advances by 8 bytes per descriptor consumed and returns to 0 after a descriptor whose bit 28 (end of table) is set. Status bits [11:0] show the position.
- R7: With overflow-continue set, a frame that runs out of posted descriptors is accepted to its end without further writes. Its header then has bit 23 set and the full frame length, and the channel returns to idle wait.
- R8: With overflow-continue clear, running out of posted descriptors mid-frame sets error 2 and state stopped (3), and `in_ready` stays low.
- R9: A first descriptor whose byte count is below the frame offset plus 4 sets error 1 and stops the channel.
- R10: A write answered with `wr_err` sets error 3. A descriptor read answered with `desc_err` sets error 4. Both stop the channel, and the stopped state always carries a non-zero error code.
- R11: `irq` pulses for exactly one cycle after a header write is granted, when the last descriptor of that frame has bit 29 set. It stays low otherwise.
- R12: Register writes select the target by `cfg_addr`: 0 is control, 1 is ring base (bits below 12 ignored), and 2 is the posted pointer as a byte position. In control, bit 0 is enable, bits [7:1] are the frame offset in bytes, and bit 10 is overflow-continue. Descriptor bits [12:0] hold the byte count and `desc_rdata[63:32]` holds the buffer address. The status word has state in [15:12] and error in [19:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| stat_o | output | 32 | Status word |
| in_valid | input | 1 | Frame word valid |
| in_ready | output | 1 | Frame word accepted |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of frame |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | 32 | Descriptor address |
| desc_gnt | input | 1 | Descriptor read grant, data valid |
| desc_err | input | 1 | Descriptor access bus error |
| desc_rdata | input | 64 | Descriptor: control word low, address high |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_gnt | input | 1 | Write grant |
| wr_err | input | 1 | Write bus error, valid with grant |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two events can land on the same clock edge: the grant of the write that empties a buffer, and the test of whether another descriptor is posted. The bench posts exactly as many buffers as a frame fills, or one fewer. The same edge must then either continue into a new buffer, drop the rest of the frame, or stop. The scoreboard compares every granted write address and data word against the list the driver computed. Status fields are then read to confirm where the channel ended up.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int DESC_BYTES = 8;

  // control register fields
  localparam int CTL_EN     = 0;
  localparam int CTL_OFF_LO = 1;
  localparam int CTL_OFF_W  = 7;
  localparam int CTL_OC     = 10;

  // descriptor control word flags
  localparam int DSC_EOT = 28;
  localparam int DSC_IOC = 29;

  // header field positions
  localparam int HDR_OVF    = 23;
  localparam int HDR_CNT_LO = 24;

  typedef enum logic [3:0] {
    ST_OFF, ST_WAIT, ST_FETCH, ST_DATA, ST_WR, ST_NEED, ST_DROP, ST_HDR, ST_STOP
  } eng_state_t;

  typedef enum logic [3:0] {
    ERR_NONE = 4'd0, ERR_PROTO = 4'd1, ERR_OVF = 4'd2, ERR_BUS_WR = 4'd3, ERR_BUS_DSC = 4'd4
  } err_t;

  localparam logic [3:0] CODE_OFF  = 4'd0;
  localparam logic [3:0] CODE_RUN  = 4'd1;
  localparam logic [3:0] CODE_IDLE = 4'd2;
  localparam logic [3:0] CODE_STOP = 4'd3;

  function automatic logic [WORD_W-1:0] pack_hdr(input logic [15:0] len,
                                                 input logic ovf,
                                                 input logic [3:0] cnt);
    logic [WORD_W-1:0] h;
    h = '0;
    h[15:0] = len;
    h[HDR_OVF] = ovf;
    h[HDR_CNT_LO +: 4] = cnt;
    return h;
  endfunction
endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [WORD_W-1:0]           cfg_wdata,
  output logic                        en,
  output logic [CTL_OFF_W-1:0]        off,
  output logic                        oc,
  output logic [ADDR_W-1:RING_BITS]   base_hi,
  output logic [RING_BITS-1:3]        posted_idx
);
  logic unused_cfg;
  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      off        <= '0;
      oc         <= 1'b0;
      base_hi    <= '0;
      posted_idx <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin
          en  <= cfg_wdata[CTL_EN];
          off <= cfg_wdata[CTL_OFF_LO +: CTL_OFF_W];
          oc  <= cfg_wdata[CTL_OC];
        end
        2'd1:    base_hi    <= cfg_wdata[ADDR_W-1:RING_BITS];
        2'd2:    posted_idx <= cfg_wdata[RING_BITS-1:3];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxdma_ring.sv
module rxdma_ring #(
  parameter int RING_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 adv,
  input  logic                 wrap,
  input  logic [RING_BITS-1:3] posted_idx,
  output logic [RING_BITS-1:0] cur_byte,
  output logic                 empty
);
  localparam int IDX_W = RING_BITS - 3;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  idx_q <= '0;
    else if (adv)    idx_q <= wrap ? '0 : idx_q + 1'b1;
  end

  assign cur_byte = {idx_q, 3'b000};
  assign empty    = (idx_q == posted_idx);
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BC_W   = 13,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [CTL_OFF_W-1:0]  off,
  input  logic                  oc,
  input  logic                  empty,
  output logic                  ring_adv,
  output logic                  ring_wrap,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  in_last,
  output logic                  desc_req,
  input  logic                  desc_gnt,
  input  logic                  desc_err,
  input  logic [2*WORD_W-1:0]   desc_rdata,
  output logic                  wr_req,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [WORD_W-1:0]     wr_data,
  input  logic                  wr_gnt,
  input  logic                  wr_err,
  output logic                  irq,
  output eng_state_t            st,
  output err_t                  err
);
  eng_state_t        st_q;
  err_t              err_q;
  logic [ADDR_W-1:0] wptr_q, hdr_addr_q;
  logic [BC_W-1:0]   left_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              last_q, first_q, ovf_q, ioc_q, irq_q;

  // descriptor decode
  logic [BC_W-1:0]   d_bc;
  logic [ADDR_W-1:0] d_addr;
  logic [BC_W:0]     need_first, left_first;
  logic [BC_W-1:0]   left_new;
  logic              proto_bad;
  logic              unused_dsc;

  assign d_bc       = desc_rdata[BC_W-1:0];
  assign d_addr     = desc_rdata[WORD_W +: ADDR_W];
  assign need_first = (BC_W+1)'(off) + (BC_W+1)'(WORD_BYTES);
  assign left_first = {1'b0, d_bc} - need_first;
  assign proto_bad  = first_q && ({1'b0, d_bc} < need_first);
  assign left_new   = first_q ? left_first[BC_W-1:0] : d_bc;
  assign unused_dsc = ^desc_rdata;

  assign ring_adv  = (st_q == ST_FETCH) && desc_gnt && !desc_err;
  assign ring_wrap = desc_rdata[DSC_EOT];

  assign in_ready = (st_q == ST_DATA) || (st_q == ST_DROP);
  assign desc_req = (st_q == ST_FETCH);
  assign wr_req   = (st_q == ST_WR) || (st_q == ST_HDR);
  assign wr_addr  = (st_q == ST_HDR) ? hdr_addr_q : wptr_q;
  assign wr_data  = (st_q == ST_HDR) ? pack_hdr(len_q, ovf_q, cnt_q) : word_q;
  assign irq      = irq_q;
  assign st       = st_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    irq_q <= 1'b0;
    if (rst || !en) begin
      st_q       <= ST_OFF;
      err_q      <= ERR_NONE;
      first_q    <= 1'b0;
      ovf_q      <= 1'b0;
      ioc_q      <= 1'b0;
      last_q     <= 1'b0;
      len_q      <= '0;
      cnt_q      <= '0;
      left_q     <= '0;
      wptr_q     <= '0;
      hdr_addr_q <= '0;
      word_q     <= '0;
    end else begin
      case (st_q)
        ST_OFF: st_q <= ST_WAIT;
        ST_WAIT: if (!empty) begin
          st_q    <= ST_FETCH;
          first_q <= 1'b1;
          ovf_q   <= 1'b0;
          len_q   <= '0;
          cnt_q   <= '0;
        end
        ST_FETCH: if (desc_gnt) begin
          if (desc_err) begin
            st_q  <= ST_STOP;
            err_q <= ERR_BUS_DSC;
          end else if (proto_bad) begin
            st_q  <= ST_STOP;
            err_q <= ERR_PROTO;
          end else begin
            ioc_q   <= desc_rdata[DSC_IOC];
            first_q <= 1'b0;
            left_q  <= left_new;
            if (first_q) begin
              hdr_addr_q <= d_addr + ADDR_W'(off);
              wptr_q     <= d_addr + ADDR_W'(off) + ADDR_W'(WORD_BYTES);
            end else begin
              wptr_q <= d_addr;
              if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
            st_q <= (left_new >= BC_W'(WORD_BYTES)) ? ST_DATA : ST_NEED;
          end
        end
        ST_DATA: if (in_valid) begin
          word_q <= in_data;
          last_q <= in_last;
          len_q  <= len_q + LEN_W'(WORD_BYTES);
          st_q   <= ST_WR;
        end
        ST_WR: if (wr_gnt) begin
          if (wr_err) begin
            st_q  <= ST_STOP;
            err_q <= ERR_BUS_WR;
          end else begin
            wptr_q <= wptr_q + ADDR_W'(WORD_BYTES);
            left_q <= left_q - BC_W'(WORD_BYTES);
            if (last_q)                                st_q <= ST_HDR;
            else if (left_q >= BC_W'(2*WORD_BYTES))    st_q <= ST_DATA;
            else                                       st_q <= ST_NEED;
          end
        end
        ST_NEED: begin
          if (!empty) st_q <= ST_FETCH;
          else if (oc) begin
            ovf_q <= 1'b1;
            st_q  <= ST_DROP;
          end else begin
            st_q  <= ST_STOP;
            err_q <= ERR_OVF;
          end
        end
        ST_DROP: if (in_valid) begin
          len_q <= len_q + LEN_W'(WORD_BYTES);
          if (in_last) st_q <= ST_HDR;
        end
        ST_HDR: if (wr_gnt) begin
          if (wr_err) begin
            st_q  <= ST_STOP;
            err_q <= ERR_BUS_WR;
          end else begin
            irq_q <= ioc_q;
            st_q  <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_BITS = 12,
  parameter int BC_W      = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    stat_o,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_data,
  input  logic                 in_last,
  output logic                 desc_req,
  output logic [ADDR_W-1:0]    desc_addr,
  input  logic                 desc_gnt,
  input  logic                 desc_err,
  input  logic [2*WORD_W-1:0]  desc_rdata,
  output logic                 wr_req,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data,
  input  logic                 wr_gnt,
  input  logic                 wr_err,
  output logic                 irq
);
  localparam int ST_LO  = 12;
  localparam int ERR_LO = 16;

  logic                       en, oc, empty, ring_adv, ring_wrap;
  logic [CTL_OFF_W-1:0]       off;
  logic [ADDR_W-1:RING_BITS]  base_hi;
  logic [RING_BITS-1:3]       posted_idx;
  logic [RING_BITS-1:0]       cur_byte;
  eng_state_t                 st;
  err_t                       err;
  logic [3:0]                 code;
  logic [WORD_W-1:0]          stat_d, stat_q;

  rxdma_regs #(.ADDR_W(ADDR_W), .RING_BITS(RING_BITS)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .en(en), .off(off), .oc(oc), .base_hi(base_hi), .posted_idx(posted_idx)
  );

  rxdma_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk(clk), .rst(rst), .clr(!en), .adv(ring_adv), .wrap(ring_wrap),
    .posted_idx(posted_idx), .cur_byte(cur_byte), .empty(empty)
  );

  rxdma_engine #(.ADDR_W(ADDR_W), .BC_W(BC_W)) u_eng (
    .clk(clk), .rst(rst), .en(en), .off(off), .oc(oc), .empty(empty),
    .ring_adv(ring_adv), .ring_wrap(ring_wrap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .desc_req(desc_req), .desc_gnt(desc_gnt), .desc_err(desc_err), .desc_rdata(desc_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt), .wr_err(wr_err),
    .irq(irq), .st(st), .err(err)
  );

  assign desc_addr = {base_hi, cur_byte};

  always_comb begin
    case (st)
      ST_OFF:  code = CODE_OFF;
      ST_STOP: code = CODE_STOP;
      ST_WAIT: code = empty ? CODE_IDLE : CODE_RUN;
      default: code = CODE_RUN;
    endcase
    stat_d = '0;
    stat_d[RING_BITS-1:0] = cur_byte;
    stat_d[ST_LO +: 4]    = code;
    stat_d[ERR_LO +: 4]   = err;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rxdma_chan_chk.sv
module rxdma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       stat_o,
  input logic              in_ready,
  input logic              desc_req,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_gnt,
  input logic              irq
);
  logic [3:0] s_state, s_err;
  logic       disabling;
  assign s_state   = stat_o[15:12];
  assign s_err     = stat_o[19:16];
  assign disabling = cfg_we && (cfg_addr == 2'd0) && !cfg_wdata[0];

  assert_disabled_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (s_state == 4'd0) |-> (stat_o[11:0] == 12'd0 && s_err == 4'd0));

  assert_idle_no_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (s_state == 4'd2) |-> !in_ready);

  assert_write_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_gnt && !disabling) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_one_request_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_req, wr_req}));

  assert_no_accept_while_writing_R5: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && wr_req));

  assert_stop_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    (s_state == 4'd3) |-> (s_err != 4'd0));

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind rxdma_chan rxdma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .stat_o(stat_o), .in_ready(in_ready), .desc_req(desc_req), .wr_req(wr_req),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt), .irq(irq)
);

// File: tb/sim_rxdma_chan.sv
`timescale 1ns/1ps
module sim_rxdma_chan;
  localparam logic [31:0] RB = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] stat_o;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        desc_req, desc_gnt = 1'b0, desc_err = 1'b0;
  logic [31:0] desc_addr;
  logic [63:0] desc_rdata = '0;
  logic        wr_req, wr_gnt = 1'b0, wr_err = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic        irq;

  always #2.5 clk = ~clk;

  rxdma_chan u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stat_o(stat_o), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .desc_req(desc_req), .desc_addr(desc_addr), .desc_gnt(desc_gnt),
    .desc_err(desc_err), .desc_rdata(desc_rdata), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_gnt(wr_gnt), .wr_err(wr_err), .irq(irq)
  );

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 1'b0, inj_wr = 1'b0, inj_dsc = 1'b0;
  logic [63:0] dtab [512];
  logic [31:0] exp_addr[$], exp_data[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [31:0] a, input logic [12:0] bc,
                                      input bit eot, input bit ioc);
    return {a, 2'b00, ioc, eot, 15'd0, bc};
  endfunction

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (!rst && wr_req && !wr_gnt) begin
      wr_gnt = 1'b1;
      wr_err = inj_wr;
      if (exp_addr.size() == 0) chk(1'b0, "unexpected write", wr_addr, 32'hx);
      else begin
        string t;
        logic [31:0] ea, ed;
        ea = exp_addr.pop_front(); ed = exp_data.pop_front(); t = exp_tag.pop_front();
        chk(wr_addr == ea, {t, " addr"}, wr_addr, ea);
        chk(wr_data == ed, {t, " data"}, wr_data, ed);
      end
    end else begin
      wr_gnt = 1'b0;
      wr_err = 1'b0;
    end
    if (!rst && desc_req && !desc_gnt) begin
      desc_gnt   = 1'b1;
      desc_err   = inj_dsc;
      desc_rdata = dtab[desc_addr[11:3]];
    end else begin
      desc_gnt = 1'b0;
      desc_err = 1'b0;
    end
  end

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input string t);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic drain(input string t);
    for (int i = 0; i < 400 && exp_addr.size() != 0; i++) @(negedge clk);
    chk(exp_addr.size() == 0, {t, " pending writes"}, exp_addr.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) dtab[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(stat_o == 32'h0, "R1 reset status", stat_o, 32'h0);
    chk(!in_ready && !wr_req && !desc_req, "R1 reset outputs", {in_ready, wr_req, desc_req}, 0);

    // R2 / R12: enable with offset 8, nothing posted
    cfg(2'd1, RB | 32'h0000_0abc);
    cfg(2'd0, 32'h0000_0011);
    repeat (4) @(negedge clk);
    chk(stat_o == 32'h0000_2000, "R2 R12 idle wait", stat_o, 32'h0000_2000);
    chk(!in_ready, "R2 backpressure", in_ready, 0);

    // R3 R4 R11: single buffer frame, offset 8
    dtab[0] = mkd(32'h2000, 13'd64, 1'b0, 1'b1);
    expect_wr(32'h200c, 32'haaaa_0001, "R3 word0");
    expect_wr(32'h2010, 32'haaaa_0002, "R3 word1");
    expect_wr(32'h2014, 32'haaaa_0003, "R3 word2");
    expect_wr(32'h2008, 32'h0000_000c, "R4 header");
    cfg(2'd2, 32'd8);
    send(32'haaaa_0001, 1'b0);
    send(32'haaaa_0002, 1'b0);
    send(32'haaaa_0003, 1'b1);
    drain("R3");
    chk(irq_cnt == 1, "R11 irq after flagged frame", irq_cnt, 1);
    chk(stat_o == 32'h0000_2008, "R6 position after frame", stat_o, 32'h0000_2008);

    // R5: scatter over two buffers, offset 0, no irq flag
    cfg(2'd0, 32'h0000_0001);
    dtab[1] = mkd(32'h3000, 13'd12, 1'b0, 1'b0);
    dtab[2] = mkd(32'h3100, 13'd16, 1'b0, 1'b0);
    expect_wr(32'h3004, 32'hbbbb_0000, "R5 w0");
    expect_wr(32'h3008, 32'hbbbb_0001, "R5 w1");
    expect_wr(32'h3100, 32'hbbbb_0002, "R5 w2");
    expect_wr(32'h3104, 32'hbbbb_0003, "R5 w3");
    expect_wr(32'h3108, 32'hbbbb_0004, "R5 w4");
    expect_wr(32'h3000, 32'h0100_0014, "R5 header");
    cfg(2'd2, 32'd24);
    for (int i = 0; i < 5; i++) send(32'hbbbb_0000 + i, i == 4);
    drain("R5");
    chk(irq_cnt == 1, "R11 no irq without flag", irq_cnt, 1);
    chk(stat_o == 32'h0000_2018, "R5 position", stat_o, 32'h0000_2018);

    // R6: end-of-table wrap
    dtab[3] = mkd(32'h4000, 13'd64, 1'b1, 1'b1);
    expect_wr(32'h4004, 32'hcccc_0000, "R6 w0");
    expect_wr(32'h4000, 32'h0000_0004, "R6 header");
    cfg(2'd2, 32'd0);
    send(32'hcccc_0000, 1'b1);
    drain("R6");
    chk(stat_o == 32'h0000_2000, "R6 wrap to 0", stat_o, 32'h0000_2000);
    chk(irq_cnt == 2, "R11 irq on wrap frame", irq_cnt, 2);

    // R7: overflow continue
    cfg(2'd0, 32'h0000_0401);
    dtab[0] = mkd(32'h5000, 13'd12, 1'b0, 1'b0);
    expect_wr(32'h5004, 32'hdddd_0000, "R7 w0");
    expect_wr(32'h5008, 32'hdddd_0001, "R7 w1");
    expect_wr(32'h5000, 32'h0080_0014, "R7 header");
    cfg(2'd2, 32'd8);
    for (int i = 0; i < 5; i++) send(32'hdddd_0000 + i, i == 4);
    drain("R7");
    chk(stat_o == 32'h0000_2008, "R7 continues idle", stat_o, 32'h0000_2008);

    // R8: overflow stop
    cfg(2'd0, 32'h0000_0001);
    dtab[1] = mkd(32'h6000, 13'd8, 1'b0, 1'b0);
    expect_wr(32'h6004, 32'heeee_0000, "R8 w0");
    cfg(2'd2, 32'd16);
    send(32'heeee_0000, 1'b0);
    drain("R8");
    chk(stat_o == 32'h0002_3010, "R8 overflow stop", stat_o, 32'h0002_3010);
    chk(!in_ready, "R8 no accept when stopped", in_ready, 0);

    cfg(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk(stat_o == 32'h0, "R1 disable clears", stat_o, 32'h0);

    // R9: first buffer too small for offset 8 plus header
    dtab[0] = mkd(32'h7000, 13'd8, 1'b0, 1'b0);
    cfg(2'd0, 32'h0000_0011);
    cfg(2'd2, 32'd8);
    repeat (8) @(negedge clk);
    chk(stat_o[19:12] == 8'h13, "R9 protocol error", stat_o[19:12], 8'h13);

    // R10: write bus error
    cfg(2'd0, 32'h0);
    dtab[0] = mkd(32'h8000, 13'd64, 1'b0, 1'b0);
    inj_wr = 1'b1;
    expect_wr(32'h8004, 32'h1234_5678, "R10 w0");
    cfg(2'd0, 32'h0000_0001);
    send(32'h1234_5678, 1'b1);
    drain("R10");
    inj_wr = 1'b0;
    chk(stat_o[19:12] == 8'h33, "R10 write bus error", stat_o[19:12], 8'h33);

    // R10: descriptor bus error
    cfg(2'd0, 32'h0);
    inj_dsc = 1'b1;
    cfg(2'd0, 32'h0000_0001);
    repeat (8) @(negedge clk);
    inj_dsc = 1'b0;
    chk(stat_o[19:12] == 8'h43, "R10 descriptor bus error", stat_o[19:12], 8'h43);
    chk(!wr_req && !in_ready, "R10 quiet when stopped", {wr_req, in_ready}, 0);

    cfg(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk(stat_o == 32'h0, "R1 final disable", stat_o, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule